// File: doc/BRIEF.md
# Word-Granular Directory Get/Put Handler

This block sits in a home-node directory controller. It serves single-word read ("get") and write ("put") requests that come from a memory-side atomic unit. Coherence is still tracked per cache block, in a small directory. Each entry holds a block state (invalid, shared or exclusive), a flag that marks the atomic unit as a sharer, and a 16-bit vector of processor-node sharers.

A get returns the coherent value of one word. If a processor owns the block exclusively, the handler first asks that owner to downgrade, writes the owner's word back to memory, and only then replies. Otherwise it reads the word from local memory. A put never invalidates anyone. It writes the word to local memory and then sends one word-update message to each sharing node, one per cycle, lowest node first. It acknowledges the put only after the last update has been taken. Processor read and exclusive requests are handled only far enough to fill in the directory. Memory, the owner-downgrade path and the update network are plain valid/ready ports.

Controller states and transitions:
- `ST_IDLE` goes to `ST_PUT_MEM` on a put, to `ST_DG_REQ` on a get to an exclusive block, and to `ST_RD_REQ` on any other get.
- `ST_RD_REQ` goes to `ST_RD_WAIT` when memory takes the read. `ST_RD_WAIT` goes to `ST_REPLY` when the data returns.
- `ST_DG_REQ` goes to `ST_DG_WAIT` when the owner takes the downgrade. `ST_DG_WAIT` goes to `ST_WB` when the owner's data arrives. `ST_WB` goes to `ST_REPLY` when memory takes the write-back.
- `ST_PUT_MEM` goes to `ST_UPD` when memory takes the write and at least one sharer exists, and to `ST_ACK` when there is no sharer.
- `ST_UPD` goes to `ST_ACK` when the last update is taken.
- `ST_REPLY` and `ST_ACK` each last one cycle and return to `ST_IDLE`.

Top module: `dirwu_top`

## Requirements
- R1: After reset every directory entry is invalid with no sharers. `req_ready` is 1, and `rsp_valid`, `mem_req_valid`, `dg_valid` and `upd_valid` are 0. A put to a never-used block therefore produces no update, and a get to such a block reads memory.
- R2: A get to a block that is not exclusive issues exactly one memory read (`mem_req_we`=0) of the request address. It then replies with `rsp_valid`=1, `rsp_is_put`=0 and the returned word. No downgrade is sent.
- R3: A get to an exclusive block sends a downgrade to the owning node for the request address. It writes the owner's returned word to memory at that address, and replies with that same word. No memory read is made.
- R4: After a get the block is shared, the atomic unit is recorded as a sharer, and every earlier sharer, including a former exclusive owner, is kept.
- R5: A put first writes its word to memory at the request address. It then sends one update carrying that address and word to every node in the sharer vector, in ascending node-ID order. Sharers are not removed, so a repeated put reaches the same nodes.
- R6: The put acknowledgement (`rsp_valid`=1, `rsp_is_put`=1) comes only after every update has been taken, and every response lasts exactly one cycle.
- R7: When the update port is always ready, consecutive updates go out on consecutive cycles. While `upd_ready` is 0, `upd_valid`, `upd_node`, `upd_addr` and `upd_data` hold steady.
- R8: A processor read adds its node to the block's sharers, and the block becomes shared. A processor exclusive request makes its node the sole sharer, and the block becomes exclusive.
- R9: The directory entry is selected by word-address bits [5:2] (4-word blocks, 16 entries). Blocks that differ only above those bits share one entry.
- R10: While a put is writing memory or fanning out updates, a processor request to the same block is stalled (`cpu_ready`=0). A request to a different block is accepted.
- R11: In `ST_IDLE`, a pending atomic-unit request takes priority: while `req_valid` is 1, `cpu_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Atomic-unit request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_is_put | input | 1 | 1 = put, 0 = get |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Put data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_is_put | output | 1 | 1 = put acknowledgement, 0 = get data |
| rsp_data | output | 32 | Get data, or the put word echoed |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Processor request accepted |
| cpu_excl | input | 1 | 1 = exclusive request, 0 = read |
| cpu_node | input | 4 | Requesting node ID |
| cpu_blk | input | 14 | Block address (word address without the 2 offset bits) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Memory word address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| dg_valid | output | 1 | Downgrade request to owner valid |
| dg_ready | input | 1 | Owner accepts downgrade |
| dg_node | output | 4 | Owner node ID |
| dg_addr | output | 16 | Word address requested from owner |
| dg_rsp_valid | input | 1 | Owner data valid |
| dg_rsp_data | input | 32 | Owner's current word |
| upd_valid | output | 1 | Word-update message valid |
| upd_ready | input | 1 | Network accepts update |
| upd_node | output | 4 | Destination node ID |
| upd_addr | output | 16 | Updated word address |
| upd_data | output | 32 | New word value |

## Verification
The bench targets the ordering corners of the fan-out. Sharers are scattered across the vector (0, 6, 15) and the update port is stalled and then toggled. A design that picked the wrong bit, or dropped a message under back-pressure, would emit a wrong or short node sequence. It also gets an exclusive block, where a design that skipped the downgrade would return stale memory data, or forget the owner and miss it on the next put. Repeated puts catch a design that clears sharers as if invalidating. Aliased blocks and a stalled put exercise the index selection and the same-block stall, where a wrong comparison would either let a processor request in mid-fan-out or deadlock an unrelated one.

// File: rtl/dirwu_pkg.sv
package dirwu_pkg;

    typedef enum logic [1:0] {
        BLK_INV = 2'd0,
        BLK_SHR = 2'd1,
        BLK_EXC = 2'd2
    } blk_state_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_DG_REQ,
        ST_DG_WAIT,
        ST_WB,
        ST_REPLY,
        ST_PUT_MEM,
        ST_UPD,
        ST_ACK
    } ctl_state_e;

endpackage

// File: rtl/dirwu_lowbit.sv
module dirwu_lowbit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dirwu_store.sv
module dirwu_store
    import dirwu_pkg::*;
#(
    parameter int NODES = 16,
    parameter int SETS  = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] ra_idx,
    output blk_state_e       ra_state,
    output logic [NODES-1:0] ra_shr,
    input  logic [IDX_W-1:0] rb_idx,
    output logic             rb_amu,
    output logic [NODES-1:0] rb_shr,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  blk_state_e       w_state,
    input  logic             w_amu,
    input  logic [NODES-1:0] w_shr
);
    blk_state_e       st_q  [SETS];
    logic             amu_q [SETS];
    logic [NODES-1:0] shr_q [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= BLK_INV;
                amu_q[g] <= 1'b0;
                shr_q[g] <= '0;
            end else if (we && w_idx == IDX_W'(g)) begin
                st_q[g]  <= w_state;
                amu_q[g] <= w_amu;
                shr_q[g] <= w_shr;
            end
        end
    end

    assign ra_state = st_q[ra_idx];
    assign ra_shr   = shr_q[ra_idx];
    assign rb_amu   = amu_q[rb_idx];
    assign rb_shr   = shr_q[rb_idx];
endmodule

// File: rtl/dirwu_top.sv
module dirwu_top
    import dirwu_pkg::*;
#(
    parameter int NODES         = 16,
    parameter int SETS          = 16,
    parameter int WORDS_PER_BLK = 4,
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 32,
    localparam int NODE_W = $clog2(NODES),
    localparam int IDX_W  = $clog2(SETS),
    localparam int OFFS_W = $clog2(WORDS_PER_BLK),
    localparam int BLK_W  = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_put,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_is_put,
    output logic [DATA_W-1:0] rsp_data,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_excl,
    input  logic [NODE_W-1:0] cpu_node,
    input  logic [BLK_W-1:0]  cpu_blk,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              dg_valid,
    input  logic              dg_ready,
    output logic [NODE_W-1:0] dg_node,
    output logic [ADDR_W-1:0] dg_addr,
    input  logic              dg_rsp_valid,
    input  logic [DATA_W-1:0] dg_rsp_data,
    output logic              upd_valid,
    input  logic              upd_ready,
    output logic [NODE_W-1:0] upd_node,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [DATA_W-1:0] upd_data
);
    ctl_state_e        st, st_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_data;
    logic [NODES-1:0]  pend, pend_low, pend_rest;

    logic [IDX_W-1:0]  ra_idx, cpu_idx;
    blk_state_e        ra_state, w_state;
    logic [NODES-1:0]  ra_shr, rb_shr, w_shr, cpu_oh;
    logic              rb_amu, w_amu, dir_we;
    logic [IDX_W-1:0]  w_idx;
    logic              fsm_we, cpu_fire, put_busy;

    assign ra_idx    = (st == ST_IDLE) ? req_addr[OFFS_W +: IDX_W] : cur_addr[OFFS_W +: IDX_W];
    assign cpu_idx   = cpu_blk[IDX_W-1:0];
    assign cpu_oh    = NODES'(1) << cpu_node;
    assign pend_low  = pend & (~pend + NODES'(1));
    assign pend_rest = pend & ~pend_low;
    assign put_busy  = (st == ST_PUT_MEM) || (st == ST_UPD);

    dirwu_store #(.NODES(NODES), .SETS(SETS)) store_i (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_state(ra_state), .ra_shr(ra_shr),
        .rb_idx(cpu_idx), .rb_amu(rb_amu), .rb_shr(rb_shr),
        .we(dir_we), .w_idx(w_idx), .w_state(w_state), .w_amu(w_amu), .w_shr(w_shr)
    );

    dirwu_lowbit #(.W(NODES)) pend_pick_i  (.vec(pend),   .idx(upd_node));
    dirwu_lowbit #(.W(NODES)) owner_pick_i (.vec(ra_shr), .idx(dg_node));

    // directory write port: controller has priority by construction of cpu_ready
    assign fsm_we   = (st == ST_IDLE && req_valid && req_is_put) || (st == ST_REPLY);
    assign cpu_fire = cpu_valid && cpu_ready;
    assign dir_we   = fsm_we || cpu_fire;

    always_comb begin
        if (fsm_we) begin
            w_idx   = ra_idx;
            w_state = BLK_SHR;
            w_amu   = 1'b1;
            w_shr   = ra_shr;
        end else if (cpu_excl) begin
            w_idx   = cpu_idx;
            w_state = BLK_EXC;
            w_amu   = 1'b0;
            w_shr   = cpu_oh;
        end else begin
            w_idx   = cpu_idx;
            w_state = BLK_SHR;
            w_amu   = rb_amu;
            w_shr   = rb_shr | cpu_oh;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (req_valid) begin
                if (req_is_put)               st_nx = ST_PUT_MEM;
                else if (ra_state == BLK_EXC) st_nx = ST_DG_REQ;
                else                          st_nx = ST_RD_REQ;
            end
            ST_RD_REQ:  if (mem_req_ready) st_nx = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rsp_valid) st_nx = ST_REPLY;
            ST_DG_REQ:  if (dg_ready)      st_nx = ST_DG_WAIT;
            ST_DG_WAIT: if (dg_rsp_valid)  st_nx = ST_WB;
            ST_WB:      if (mem_req_ready) st_nx = ST_REPLY;
            ST_REPLY:                      st_nx = ST_IDLE;
            ST_PUT_MEM: if (mem_req_ready) st_nx = (pend == '0) ? ST_ACK : ST_UPD;
            ST_UPD:     if (upd_ready && pend_rest == '0) st_nx = ST_ACK;
            ST_ACK:                        st_nx = ST_IDLE;
            default:                       st_nx = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_data <= '0;
            pend     <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    cur_addr <= req_addr;
                    cur_data <= req_wdata;
                    pend     <= req_is_put ? ra_shr : '0;
                end
                ST_RD_WAIT: if (mem_rsp_valid) cur_data <= mem_rsp_data;
                ST_DG_WAIT: if (dg_rsp_valid)  cur_data <= dg_rsp_data;
                ST_UPD:     if (upd_ready)     pend     <= pend_rest;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (st == ST_IDLE);
        cpu_ready     = (st == ST_IDLE && !req_valid) ||
                        (put_busy && cpu_blk != cur_addr[ADDR_W-1:OFFS_W]);
        mem_req_valid = (st == ST_RD_REQ) || (st == ST_WB) || (st == ST_PUT_MEM);
        mem_req_we    = (st == ST_WB) || (st == ST_PUT_MEM);
        mem_req_addr  = cur_addr;
        mem_req_wdata = cur_data;
        dg_valid      = (st == ST_DG_REQ);
        dg_addr       = cur_addr;
        upd_valid     = (st == ST_UPD);
        upd_addr      = cur_addr;
        upd_data      = cur_data;
        rsp_valid     = (st == ST_REPLY) || (st == ST_ACK);
        rsp_is_put    = (st == ST_ACK);
        rsp_data      = cur_data;
    end
endmodule

// File: rtl/dirwu_chk.sv
module dirwu_chk #(
    parameter int ADDR_W = 16,
    parameter int OFFS_W = 2,
    parameter int NODE_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_is_put,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic [ADDR_W-OFFS_W-1:0] cpu_blk,
    input logic              mem_req_valid,
    input logic              dg_valid,
    input logic              upd_valid,
    input logic              upd_ready,
    input logic [NODE_W-1:0] upd_node,
    input logic [ADDR_W-1:0] upd_addr,
    input logic [DATA_W-1:0] upd_data,
    input logic              fsm_we,
    input logic              cpu_fire
);
    // R7
    upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !upd_ready |=> upd_valid && $stable(upd_node) && $stable(upd_addr) && $stable(upd_data));

    // R5
    upd_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_ready |=> !upd_valid || (upd_node > $past(upd_node)));

    // R6
    ack_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_is_put |-> !upd_valid);

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10
    same_blk_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && cpu_valid && cpu_blk == upd_addr[ADDR_W-1:OFFS_W] |-> !cpu_ready);

    // R11
    amu_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> !cpu_ready);

    // R3
    one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_valid, dg_valid, upd_valid, rsp_valid}));

    // R8
    dir_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fsm_we && cpu_fire));
endmodule

bind dirwu_top dirwu_chk #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .NODE_W(NODE_W), .DATA_W(DATA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_is_put(rsp_is_put),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_blk(cpu_blk),
    .mem_req_valid(mem_req_valid), .dg_valid(dg_valid),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_node(upd_node),
    .upd_addr(upd_addr), .upd_data(upd_data),
    .fsm_we(fsm_we), .cpu_fire(cpu_fire)
);

// File: tb/dirwu_top_tb_top.sv
module dirwu_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req_valid = 0, req_is_put = 0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_is_put;
    logic [31:0] rsp_data;
    logic        cpu_valid = 0, cpu_excl = 0;
    logic [3:0]  cpu_node = '0;
    logic [13:0] cpu_blk = '0;
    logic        cpu_ready;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready = 1'b1;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = '0;
    logic        dg_valid;
    logic        dg_ready = 1'b1;
    logic [3:0]  dg_node;
    logic [15:0] dg_addr;
    logic        dg_rsp_valid = 0;
    logic [31:0] dg_rsp_data = '0;
    logic        upd_valid;
    logic        upd_ready = 1'b1;
    logic [3:0]  upd_node;
    logic [15:0] upd_addr;
    logic [31:0] upd_data;

    dirwu_top dut_i (.*);

    int total = 0, bad = 0, cyc = 0;
    int n_rd = 0, n_wr = 0, n_dg = 0, n_upd = 0;
    logic [15:0] rd_addr_l, wr_addr_l, dg_addr_l;
    logic [31:0] wr_data_l;
    logic [3:0]  dg_node_l;
    logic [3:0]  log_node [256];
    logic [15:0] log_addr [256];
    logic [31:0] log_data [256];
    int          log_cyc  [256];
    int          upd_mode = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        dg_rsp_valid  <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                n_wr <= n_wr + 1; wr_addr_l <= mem_req_addr; wr_data_l <= mem_req_wdata;
            end else begin
                n_rd <= n_rd + 1; rd_addr_l <= mem_req_addr;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= {16'hC0DE, mem_req_addr};
            end
        end
        if (dg_valid && dg_ready) begin
            n_dg <= n_dg + 1; dg_node_l <= dg_node; dg_addr_l <= dg_addr;
            dg_rsp_valid <= 1'b1;
            dg_rsp_data  <= {8'hD0, 4'h0, dg_node, dg_addr};
        end
        if (upd_valid && upd_ready) begin
            log_node[n_upd[7:0]] <= upd_node;
            log_addr[n_upd[7:0]] <= upd_addr;
            log_data[n_upd[7:0]] <= upd_data;
            log_cyc[n_upd[7:0]]  <= cyc;
            n_upd <= n_upd + 1;
        end
    end

    always @(negedge clk) begin
        case (upd_mode)
            0: upd_ready <= 1'b1;
            1: upd_ready <= 1'b0;
            default: upd_ready <= ~upd_ready;
        endcase
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic amu_op(input logic put, input logic [15:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic rput);
        @(negedge clk);
        req_valid = 1; req_is_put = put; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid) @(negedge clk);
        rd = rsp_data; rput = rsp_is_put;
        @(negedge clk);
    endtask

    task automatic cpu_op(input logic ex, input logic [3:0] n, input logic [13:0] b);
        @(negedge clk);
        cpu_valid = 1; cpu_excl = ex; cpu_node = n; cpu_blk = b;
        #1;
        while (!cpu_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cpu_valid = 0;
    endtask

    // put and compare the node list of its fan-out
    task automatic put_expect(input string tag, input logic [15:0] a, input logic [31:0] d,
                              input int cnt, input logic [3:0] n0, input logic [3:0] n1,
                              input logic [3:0] n2);
        logic [31:0] r; logic p; int b0, w0;
        logic [3:0] en [3];
        en[0] = n0; en[1] = n1; en[2] = n2;
        b0 = n_upd; w0 = n_wr;
        amu_op(1'b1, a, d, r, p);
        chk({tag, " ack kind"}, {31'd0, p}, 32'd1);
        chk({tag, " upd count at ack"}, n_upd - b0, cnt);
        chk({tag, " mem write count"}, n_wr - w0, 1);
        chk({tag, " mem write addr"}, {16'd0, wr_addr_l}, {16'd0, a});
        chk({tag, " mem write data"}, wr_data_l, d);
        for (int i = 0; i < cnt; i++) begin
            chk({tag, " upd node"}, {28'd0, log_node[(b0 + i) % 256]}, {28'd0, en[i]});
            chk({tag, " upd addr/data"}, log_data[(b0 + i) % 256] ^ {16'd0, log_addr[(b0 + i) % 256]},
                d ^ {16'd0, a});
        end
    endtask

    task automatic t_reset;
        logic [31:0] r; logic p; int r0;
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 idle outputs", {28'd0, rsp_valid, mem_req_valid, dg_valid, upd_valid}, 32'd0);
        put_expect("R1 fresh put", 16'h0010, 32'h11111111, 0, 0, 0, 0);
        r0 = n_rd;
        amu_op(1'b0, 16'h0057, 32'd0, r, p);
        chk("R1 fresh get reads memory", n_rd - r0, 1);
    endtask

    task automatic t_plain_get;
        logic [31:0] r; logic p; int r0, d0;
        cpu_op(1'b0, 4'd3, 14'h008);
        cpu_op(1'b0, 4'd9, 14'h008);
        r0 = n_rd; d0 = n_dg;
        amu_op(1'b0, 16'h0022, 32'd0, r, p);
        chk("R2 get data", r, 32'hC0DE0022);
        chk("R2 get kind", {31'd0, p}, 32'd0);
        chk("R2 one read", n_rd - r0, 1);
        chk("R2 read addr", {16'd0, rd_addr_l}, 32'h0022);
        chk("R2 no downgrade", n_dg - d0, 0);
    endtask

    task automatic t_put_fanout;
        int b0;
        b0 = n_upd;
        put_expect("R5 put", 16'h0023, 32'h12345678, 2, 4'd3, 4'd9, 0);
        chk("R7 back-to-back updates", log_cyc[(b0 + 1) % 256] - log_cyc[b0 % 256], 1);
        put_expect("R5 repeat put keeps sharers", 16'h0023, 32'hCAFEF00D, 2, 4'd3, 4'd9, 0);
    endtask

    task automatic t_excl_get;
        logic [31:0] r; logic p; int r0, d0, w0;
        cpu_op(1'b1, 4'd11, 14'h011);
        r0 = n_rd; d0 = n_dg; w0 = n_wr;
        amu_op(1'b0, 16'h0045, 32'd0, r, p);
        chk("R3 downgrade count", n_dg - d0, 1);
        chk("R3 downgrade node", {28'd0, dg_node_l}, 32'd11);
        chk("R3 downgrade addr", {16'd0, dg_addr_l}, 32'h0045);
        chk("R3 write-back", n_wr - w0, 1);
        chk("R3 write-back data", wr_data_l, 32'hD00B0045);
        chk("R3 reply owner data", r, 32'hD00B0045);
        chk("R3 no memory read", n_rd - r0, 0);
        cpu_op(1'b0, 4'd2, 14'h011);
        put_expect("R4 owner kept as sharer", 16'h0046, 32'hA1A2A3A4, 2, 4'd2, 4'd11, 0);
        r0 = n_rd; d0 = n_dg;
        amu_op(1'b0, 16'h0047, 32'd0, r, p);
        chk("R4 block now shared: read", n_rd - r0, 1);
        chk("R4 block now shared: no downgrade", n_dg - d0, 0);
        chk("R4 shared get data", r, 32'hC0DE0047);
    endtask

    task automatic t_cpu_excl;
        logic [31:0] r; logic p;
        cpu_op(1'b1, 4'd5, 14'h008);
        amu_op(1'b0, 16'h0020, 32'd0, r, p);
        chk("R8 exclusive owner downgraded", {28'd0, dg_node_l}, 32'd5);
        chk("R8 owner data", r, 32'hD0050020);
        put_expect("R8 exclusive replaced sharers", 16'h0021, 32'h0BADBEEF, 1, 4'd5, 0, 0);
    endtask

    task automatic t_alias;
        cpu_op(1'b0, 4'd14, 14'h043);
        put_expect("R9 aliased entry", 16'h000C, 32'h5A5A5A5A, 1, 4'd14, 0, 0);
    endtask

    task automatic t_stall;
        logic [31:0] r; int b0;
        cpu_op(1'b0, 4'd15, 14'h020);
        cpu_op(1'b0, 4'd0,  14'h020);
        cpu_op(1'b0, 4'd6,  14'h020);
        b0 = n_upd;
        upd_mode = 1;
        @(negedge clk);
        req_valid = 1; req_is_put = 1; req_addr = 16'h0081; req_wdata = 32'h600DF00D;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 0;
        while (!upd_valid) @(negedge clk);
        cpu_valid = 1; cpu_excl = 0; cpu_node = 4'd12; cpu_blk = 14'h020;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R10 same block stalled", {31'd0, cpu_ready}, 32'd0);
            chk("R7 held update node", {27'd0, upd_valid, upd_node}, 32'h10);
            @(negedge clk);
        end
        cpu_node = 4'd1; cpu_blk = 14'h024;
        #1;
        chk("R10 other block accepted", {31'd0, cpu_ready}, 32'd1);
        @(negedge clk);
        cpu_valid = 0;
        upd_mode = 2;
        while (!rsp_valid) @(negedge clk);
        r = rsp_data;
        chk("R6 ack after all updates", n_upd - b0, 3);
        chk("R7 ack data", r, 32'h600DF00D);
        chk("R5 order 0", {28'd0, log_node[b0 % 256]}, 32'd0);
        chk("R5 order 6", {28'd0, log_node[(b0 + 1) % 256]}, 32'd6);
        chk("R5 order 15", {28'd0, log_node[(b0 + 2) % 256]}, 32'd15);
        upd_mode = 0;
        @(negedge clk);
        @(negedge clk);
        put_expect("R10 accepted request recorded", 16'h0090, 32'h77778888, 1, 4'd1, 0, 0);
        put_expect("R10 stalled request not recorded", 16'h0082, 32'h99990000, 3, 4'd0, 4'd6, 4'd15);
    endtask

    task automatic t_priority;
        @(negedge clk);
        req_valid = 1; req_is_put = 0; req_addr = 16'h0030;
        cpu_valid = 1; cpu_excl = 0; cpu_node = 4'd4; cpu_blk = 14'h00C;
        #1;
        chk("R11 atomic request ready", {31'd0, req_ready}, 32'd1);
        chk("R11 processor held off", {31'd0, cpu_ready}, 32'd0);
        @(negedge clk);
        req_valid = 0;
        while (!rsp_valid) @(negedge clk);
        chk("R11 get completes", rsp_data, 32'hC0DE0030);
        #1;
        while (!cpu_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cpu_valid = 0;
        put_expect("R8 read adds sharer", 16'h0031, 32'h01020304, 1, 4'd4, 0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_get();
        t_put_fanout();
        t_excl_get();
        t_cpu_excl();
        t_alias();
        t_stall();
        t_priority();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule